// File: doc/BRIEF.md
# Locked-Write Watchdog Timer

This block is a watchdog timer. Software controls it through one 8-bit control and status register on a plain register bus. The bus has an address, a write strobe, write data and combinational read data. A slow tick-enable input, nominally 32.768 kHz, advances an internal counter. A 4-bit prescale code sets the timeout length. While the watchdog is armed, software must re-arm it before the timeout runs out. If it does not, the block either issues a one-clock system-reset request or raises a high-priority interrupt request that stays up until acknowledged.

The register is protected against stray stores. A store to the control register that arrives while the block is locked only records the unlock bit. Only the next bus write can change the other fields, and that write always consumes the unlock, whichever address it targets. The timeout flag survives a watchdog-caused reset. Only software or the hardware reset input clears it. A supply-monitor event disarms the watchdog.

Register layout, most significant bit first:
- bits 7:4: prescale code
- bit 3: interrupt mode
- bit 2: timeout flag
- bit 1: arm / kick
- bit 0: unlock

Top module: `wdt_guard`

## Requirements
- R1: After `rst_n` is low, the register reads 0x10 (code 1, all other bits 0). Both `rst_req` and `irq_req` are low.
- R2: A write to the control address while locked changes only bit 0, which takes the written bit 0. Bits 7:1 keep their values.
- R3: While unlocked, the next bus write to any address clears the unlock. If that write targets the control address, bits 7:1 load from the write data, except that bit 2 follows R9. Bit 0 then reads 0.
- R4: For codes 0 to 7, the timeout is 2^(code+BASE_SHIFT) ticks. An accepted write with bit 1 set arms the watchdog and restarts the count from zero. Expiry is registered on the edge that takes the last tick.
- R5: Code 8 with bit 1 set forces a reset request on the next clock edge, whatever the mode.
- R6: Codes 9 to 15 never expire. The watchdog stays armed and neither request rises.
- R7: A reset-mode expiry gives a `rst_req` pulse exactly one clock long. It clears bit 1, sets bit 2, and keeps the code and mode bits.
- R8: In interrupt mode (bit 3 = 1), each expiry sets `irq_req`. It stays high until `irq_ack`. The count restarts from zero, so expiries repeat every timeout period with bit 1 still set.
- R9: Expiry sets bit 2. An accepted write with bit 2 = 0 clears it, and one with bit 2 = 1 leaves it as it is. A watchdog reset keeps it, and `rst_n` clears it.
- R10: A `psm_evt` pulse clears bit 1 and stops the count.
- R11: A read of any address other than `CTRL_ADDR` returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| tick_en | input | 1 | One-clock enable per slow tick |
| psm_evt | input | 1 | Supply-monitor event, disarms the watchdog |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_ack | input | 1 | Clears a pending interrupt request |
| rst_req | output | 1 | One-clock reset request |
| irq_req | output | 1 | Level interrupt request |

## Verification
On every cycle, assertions check these properties:
- the reset request is one clock long;
- the interrupt request is held until acknowledged;
- a locked store leaves the code and mode bits unchanged;
- every write consumes the unlock;
- the flag follows each expiry;
- a supply-monitor event disarms the watchdog;
- the counter stays below the selected span.

Only the bench scenarios can show the exact cycle of each timeout across all eight counting codes, the restart after a mid-period kick, the immediate code, the silence of the reserved codes, the interrupt period, and the flag's survival until a hardware reset.

// File: rtl/wdt_guard_pkg.sv
`timescale 1ns/1ps
package wdt_guard_pkg;

  localparam logic [3:0] PRE_IMMEDIATE = 4'd8;
  localparam logic [3:0] PRE_RESET     = 4'd1;

  // ticks in one timeout period for a counting code
  function automatic logic [31:0] span_ticks(input logic [3:0] pre,
                                             input int unsigned shift);
    return 32'd1 << (32'(pre) + shift);
  endfunction

  function automatic logic code_counts(input logic [3:0] pre);
    return pre < PRE_IMMEDIATE;
  endfunction

endpackage

// File: rtl/wdt_gate.sv
`timescale 1ns/1ps
module wdt_gate #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit0,
  output logic              unlocked,
  output logic              accept
);
  logic hit;
  assign hit    = (addr == ADDR_W'(CTRL_ADDR));
  assign accept = we && hit && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (we) begin
      if (unlocked)          unlocked <= 1'b0;
      else if (hit && wbit0) unlocked <= 1'b1;
    end
  end

  // R3: any write consumes the unlock
  a_r3_unlock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (we && unlocked) |=> !unlocked);

endmodule

// File: rtl/wdt_tick_counter.sv
`timescale 1ns/1ps
module wdt_tick_counter
  import wdt_guard_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BASE_SHIFT = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] pre,
  input  logic       tick,
  input  logic       restart,
  output logic       expire
);
  localparam int unsigned MAX_SPAN_LOG = 7 + BASE_SHIFT;

  logic [CNT_W-1:0] cnt;
  logic [31:0]      span;
  logic             counting, terminal, immediate;

  assign span      = span_ticks(pre, BASE_SHIFT);
  assign counting  = run && code_counts(pre);
  assign terminal  = (32'(cnt) == span - 32'd1);
  assign immediate = run && (pre == PRE_IMMEDIATE);
  assign expire    = immediate || (counting && tick && terminal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run) begin
      cnt <= '0;
    end else if (counting && tick) begin
      cnt <= terminal ? '0 : cnt + 1'b1;
    end
  end

  initial begin
    if (CNT_W < MAX_SPAN_LOG)
      $error("wdt_tick_counter: CNT_W too small for BASE_SHIFT");
  end

  // R4: the count never reaches the selected span
  a_r4_cnt_below_span: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> (32'(cnt) < span));

endmodule

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned CTRL_ADDR  = 0,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BASE_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              psm_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              irq_ack,
  output logic              rst_req,
  output logic              irq_req
);
  logic [3:0] pre_q;
  logic       mode_q, flag_q, run_q;
  logic       unlocked, accept, expire, restart;
  logic       fire_reset, fire_irq, hit;

  assign hit = (bus_addr == ADDR_W'(CTRL_ADDR));

  wdt_gate #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_gate (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wbit0(bus_wdata[0]), .unlocked(unlocked), .accept(accept)
  );

  assign restart = (accept && bus_wdata[1]) || psm_evt;

  wdt_tick_counter #(.CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .pre(pre_q), .tick(tick_en),
    .restart(restart), .expire(expire)
  );

  // expiry routing: code 8 always resets
  assign fire_reset = expire && (!mode_q || pre_q == PRE_IMMEDIATE);
  assign fire_irq   = expire && mode_q && (pre_q != PRE_IMMEDIATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= PRE_RESET;
      mode_q  <= 1'b0;
      flag_q  <= 1'b0;
      run_q   <= 1'b0;
      rst_req <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      rst_req <= fire_reset;
      if (accept) begin
        pre_q  <= bus_wdata[7:4];
        mode_q <= bus_wdata[3];
      end
      if (expire)                       flag_q <= 1'b1;
      else if (accept && !bus_wdata[2]) flag_q <= 1'b0;
      if (psm_evt)         run_q <= 1'b0;
      else if (fire_reset) run_q <= 1'b0;
      else if (accept)     run_q <= bus_wdata[1];
      if (fire_irq)     irq_req <= 1'b1;
      else if (irq_ack) irq_req <= 1'b0;
    end
  end

  assign bus_rdata = hit ? {pre_q, mode_q, flag_q, run_q, unlocked} : 8'h00;

  // R7: reset request lasts one clock and disarms with the flag set
  a_r7_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r7_reset_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!run_q && flag_q));
  // R8: interrupt held until acknowledged
  a_r8_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req);
  // R2: locked store keeps code and mode
  a_r2_locked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit && !unlocked) |=> ($stable(pre_q) && $stable(mode_q)));
  // R9: flag follows each expiry
  a_r9_flag_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  // R10: supply-monitor event disarms
  a_r10_psm_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    psm_evt |=> !run_q);

endmodule

// File: tb/test_wdt_guard.sv
`timescale 1ns/1ps
module test_wdt_guard;
  localparam int SHIFT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       psm_evt = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       rst_req, irq_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdt_guard #(.ADDR_W(4), .CTRL_ADDR(0), .CNT_W(16), .BASE_SHIFT(SHIFT)) i_wdt_guard (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psm_evt(psm_evt),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .rst_req(rst_req), .irq_req(irq_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #2 bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic uwr(input logic [7:0] d);
    wr(4'd0, 8'h01);
    wr(4'd0, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata; bus_addr = '0;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  logic [7:0] v;

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hw_reset();
    // R1
    rd(4'd0, v); check(v == 8'h10, "R1 reset value", v, 8'h10);
    check(!rst_req && !irq_req, "R1 requests low", {rst_req, irq_req}, 0);
    // R11
    rd(4'd3, v); check(v == 8'h00, "R11 other address", v, 0);
    // R2 locked store
    wr(4'd0, 8'hF2); rd(4'd0, v); check(v == 8'h10, "R2 locked ignored", v, 8'h10);
    wr(4'd0, 8'h83); rd(4'd0, v); check(v == 8'h11, "R2 only unlock taken", v, 8'h11);
    // R3 consumed by a write elsewhere
    wr(4'd5, 8'h00); rd(4'd0, v); check(v == 8'h10, "R3 unlock consumed", v, 8'h10);
    wr(4'd0, 8'h72); rd(4'd0, v); check(v == 8'h10, "R3 stale store ignored", v, 8'h10);
    uwr(8'h98); rd(4'd0, v); check(v == 8'h98, "R3 accepted write", v, 8'h98);

    // R4/R7 sweep of counting codes, reset mode
    for (int code = 0; code < 8; code++) begin
      int lim;
      lim = 1 << (code + SHIFT);
      hw_reset();
      uwr({code[3:0], 4'b0010});
      for (int n = 1; n <= lim + 1; n++) begin
        step();
        check(rst_req == (n == lim), $sformatf("R4 code %0d tick %0d", code, n),
              rst_req, (n == lim));
      end
      rd(4'd0, v);
      check(v == {code[3:0], 4'b0100}, "R7 fields after reset", v, {code[3:0], 4'b0100});
    end
    // R9 flag: write 1 keeps, write 0 clears, hw reset clears
    uwr(8'h74); rd(4'd0, v); check(v == 8'h74, "R9 write one keeps flag", v, 8'h74);
    uwr(8'h70); rd(4'd0, v); check(v == 8'h70, "R9 write zero clears", v, 8'h70);
    uwr(8'h22);
    for (int n = 0; n < 20; n++) step();
    rd(4'd0, v); check(v[2] == 1'b1, "R9 flag survives wd reset", v[2], 1);
    hw_reset(); rd(4'd0, v); check(v == 8'h10, "R9 hw reset clears", v, 8'h10);

    // R4 kick restarts the count (code 2, 16 ticks)
    uwr(8'h22);
    for (int n = 0; n < 8; n++) begin
      step(); check(!rst_req, "R4 early", rst_req, 0);
    end
    uwr(8'h22);
    for (int n = 1; n <= 17; n++) begin
      step(); check(rst_req == (n == 16), $sformatf("R4 after kick tick %0d", n), rst_req, (n == 16));
    end

    // R5 immediate code, both modes
    hw_reset(); uwr(8'h82);
    step(); check(rst_req == 1'b1, "R5 immediate", rst_req, 1);
    step(); check(rst_req == 1'b0, "R5 single pulse", rst_req, 0);
    uwr(8'h8A);
    step(); check(rst_req && !irq_req, "R5 immediate in irq mode", {rst_req, irq_req}, 2);

    // R6 reserved code stays quiet
    hw_reset(); uwr(8'h92);
    for (int n = 0; n < 2000; n++) begin
      step();
      if (rst_req || irq_req) check(1'b0, "R6 reserved fired", {rst_req, irq_req}, 0);
    end
    rd(4'd0, v); check(v == 8'h92, "R6 still armed", v, 8'h92);

    // R8 interrupt mode, code 1 (8 ticks)
    hw_reset(); uwr(8'h1A);
    for (int n = 1; n <= 24; n++) begin
      bit e;
      step();
      if (n == 17) irq_ack = 1'b0;
      e = (n >= 8 && n <= 16) || n == 24;
      check(irq_req == e && !rst_req, $sformatf("R8 irq tick %0d", n), irq_req, e);
      if (n == 16) irq_ack = 1'b1;
    end
    bus_addr = 4'd0; #1 check(bus_rdata[1] == 1'b1, "R8 stays armed", bus_rdata[1], 1);

    // R10 supply-monitor event
    hw_reset(); uwr(8'h02);
    step(); step();
    @(negedge clk); psm_evt = 1'b1; @(negedge clk); psm_evt = 1'b0;
    rd(4'd0, v); check(v[1] == 1'b0, "R10 disarmed", v[1], 0);
    for (int n = 0; n < 12; n++) begin
      step(); if (rst_req) check(1'b0, "R10 fired after disarm", rst_req, 0);
    end
    check(!rst_req, "R10 no reset", rst_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule